// File: doc/BRIEF.md
# Weighted Hysteresis Threshold Gate

This block is a state-holding threshold element of the kind used to build delay-insensitive dual-rail logic, recast as a clocked register for an FPGA fabric. Up to four single-bit inputs each carry an integer weight. When the output is low and the weighted count of high inputs reaches the threshold, the output goes high. It then stays high for as long as any active input is still high. It drops only after every active input has returned low. A synchronous reset loads a parameter-chosen value, either 0 or 1.

A parameter picks one of the predefined variants: two-, three- and four-input completion gates (all inputs must be high), two-, three- and four-input "any" gates, a two-of-three majority, and the four-input gate with threshold 3 whose first input counts double. A custom variant takes the input count, threshold and weights directly. Input `in_bits[0]` is the first input, and its weight sits in the lowest nibble of the weight vector. The state and output are one register, so every input change shows up at the output one clock later.

Top module: `thg_gate`

## Requirements
- R1: While `rst` is high at a rising clock edge, `gate_out` takes the value RST_VAL after that edge, whatever the inputs are. Reset has priority over the set and hold rules.
- R2: If `gate_out` is 0 and the weighted sum of high active inputs is at least the threshold M, `gate_out` is 1 after the next rising edge.
- R3: If `gate_out` is 0 and the weighted sum is below M, `gate_out` stays 0, even with some inputs high.
- R4: If `gate_out` is 1 and at least one active input is high, `gate_out` stays 1, even when the weighted sum is below M.
- R5: If `gate_out` is 1 and every active input is low, `gate_out` is 0 after the next rising edge.
- R6: The default variant has 4 inputs, threshold 3 and weight 2 on `in_bits[0]` (weight 1 elsewhere). From the low state it sets exactly on in0&in1 | in0&in2 | in0&in3 | in1&in2&in3.
- R7: The three-input completion variant (M = N = 3) sets only when `in_bits[2:0]` are all high, and clears only when all three are low.
- R8: The four-input "any" variant (M = 1) acts as a registered OR of `in_bits[3:0]`.
- R9: Input positions at or above the variant's input count N have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset, loads RST_VAL |
| in_bits | input | 4 | Gate inputs; bit 0 is the first (weighted) input |
| gate_out | output | 1 | Registered gate output |

## Verification
Several points are targeted:
- A partial input set that leaves the output high. A design that re-evaluated the threshold every cycle would drop early here, breaking the hold.
- Sub-threshold patterns with inputs high. A design that set on any high input would wrongly rise.
- Every one of the sixteen patterns on the weighted variant. A wrong weight or lane order sets on the wrong minterms.
- A high bit above N on the three-input completion variant. A design that failed to mask it would set or hold.
- Reset asserted while inputs are high, on both reset values. A design that put reset below the hold path would keep the old state.

// File: rtl/thg_pkg.sv
package thg_pkg;
  localparam int NMAX  = 4;
  localparam int WBITS = 4;
  localparam int SUM_W = $clog2(NMAX * ((1 << WBITS) - 1) + 1);

  typedef enum int {
    GK_CUSTOM,
    GK_CEL2,
    GK_CEL3,
    GK_CEL4,
    GK_ANY2,
    GK_ANY3,
    GK_ANY4,
    GK_MAJ3,
    GK_W2_3OF4
  } gate_kind_e;

  function automatic int kind_n(gate_kind_e k, int cust_n);
    case (k)
      GK_CEL2, GK_ANY2:                return 2;
      GK_CEL3, GK_ANY3, GK_MAJ3:       return 3;
      GK_CEL4, GK_ANY4, GK_W2_3OF4:    return 4;
      default:                         return cust_n;
    endcase
  endfunction

  function automatic int kind_m(gate_kind_e k, int cust_m);
    case (k)
      GK_ANY2, GK_ANY3, GK_ANY4:       return 1;
      GK_CEL2, GK_MAJ3:                return 2;
      GK_CEL3, GK_W2_3OF4:             return 3;
      GK_CEL4:                         return 4;
      default:                         return cust_m;
    endcase
  endfunction

  function automatic logic [NMAX*WBITS-1:0] kind_w(gate_kind_e k,
                                                  logic [NMAX*WBITS-1:0] cust_w);
    case (k)
      GK_CUSTOM:  return cust_w;
      GK_W2_3OF4: return 16'h1112;
      default:    return 16'h1111;
    endcase
  endfunction
endpackage

// File: rtl/thg_mask.sv
module thg_mask #(
  parameter int N = 4
) (
  input  logic [thg_pkg::NMAX-1:0] in_bits,
  output logic [thg_pkg::NMAX-1:0] act_o,
  output logic                     any_o
);
  for (genvar k = 0; k < thg_pkg::NMAX; k++) begin : g_lane
    if (k < N) begin : g_live
      assign act_o[k] = in_bits[k];
    end else begin : g_dead
      assign act_o[k] = 1'b0;
    end
  end

  assign any_o = |act_o;
endmodule

// File: rtl/thg_wsum.sv
module thg_wsum #(
  parameter int M = 1,
  parameter logic [thg_pkg::NMAX*thg_pkg::WBITS-1:0] W = '1
) (
  input  logic [thg_pkg::NMAX-1:0] act_i,
  output logic                     reach_o
);
  localparam int SW = thg_pkg::SUM_W;

  logic [SW-1:0] term [thg_pkg::NMAX];
  logic [SW-1:0] sum;

  for (genvar k = 0; k < thg_pkg::NMAX; k++) begin : g_term
    assign term[k] = act_i[k] ? SW'(W[k*thg_pkg::WBITS +: thg_pkg::WBITS]) : '0;
  end

  always_comb begin
    sum = '0;
    for (int k = 0; k < thg_pkg::NMAX; k++) sum = sum + term[k];
  end

  assign reach_o = (sum >= SW'(M));
endmodule

// File: rtl/thg_hold.sv
module thg_hold #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic reach_i,
  input  logic any_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (rst)        q_o <= RST_VAL;
    else if (!q_o)  q_o <= reach_i;
    else            q_o <= any_i;
  end

  AST_RESET_LOADS: assert property (@(posedge clk)
    $past(rst) |-> (q_o == RST_VAL)); // R1
  AST_SET_ON_REACH: assert property (@(posedge clk) disable iff (rst)
    (!q_o && reach_i) |=> q_o); // R2
  AST_LOW_BELOW: assert property (@(posedge clk) disable iff (rst)
    (!q_o && !reach_i) |=> !q_o); // R3
  AST_HOLD_HIGH: assert property (@(posedge clk) disable iff (rst)
    (q_o && any_i) |=> q_o); // R4
  AST_CLEAR_IDLE: assert property (@(posedge clk) disable iff (rst)
    (q_o && !any_i) |=> !q_o); // R5
endmodule

// File: rtl/thg_gate.sv
module thg_gate #(
  parameter thg_pkg::gate_kind_e KIND = thg_pkg::GK_W2_3OF4,
  parameter int CUST_N = 4,
  parameter int CUST_M = 2,
  parameter logic [thg_pkg::NMAX*thg_pkg::WBITS-1:0] CUST_W = 16'h1111,
  parameter bit RST_VAL = 1'b0
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [thg_pkg::NMAX-1:0] in_bits,
  output logic                     gate_out
);
  localparam int N = thg_pkg::kind_n(KIND, CUST_N);
  localparam int M = thg_pkg::kind_m(KIND, CUST_M);
  localparam logic [thg_pkg::NMAX*thg_pkg::WBITS-1:0] W = thg_pkg::kind_w(KIND, CUST_W);

  logic [thg_pkg::NMAX-1:0] act;
  logic any_hi;
  logic reach;

  thg_mask #(.N(N)) u_mask (
    .in_bits (in_bits),
    .act_o   (act),
    .any_o   (any_hi)
  );

  thg_wsum #(.M(M), .W(W)) u_wsum (
    .act_i   (act),
    .reach_o (reach)
  );

  thg_hold #(.RST_VAL(RST_VAL)) u_hold (
    .clk     (clk),
    .rst     (rst),
    .reach_i (reach),
    .any_i   (any_hi),
    .q_o     (gate_out)
  );
endmodule

// File: tb/thg_gate_test.sv
`timescale 1ns/1ps
module thg_gate_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] stim = 4'b0000;
  logic [3:0] outs;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  thg_gate uut (.clk(clk), .rst(rst), .in_bits(stim), .gate_out(outs[0]));
  thg_gate #(.KIND(thg_pkg::GK_CEL3)) uut_cel
    (.clk(clk), .rst(rst), .in_bits(stim), .gate_out(outs[1]));
  thg_gate #(.KIND(thg_pkg::GK_ANY4)) uut_any
    (.clk(clk), .rst(rst), .in_bits(stim), .gate_out(outs[2]));
  thg_gate #(.KIND(thg_pkg::GK_CUSTOM), .CUST_N(3), .CUST_M(2),
             .CUST_W(16'h0112), .RST_VAL(1'b1)) uut_cus
    (.clk(clk), .rst(rst), .in_bits(stim), .gate_out(outs[3]));

  // Reference: weights per instance and lane, threshold, input count, reset value
  int wt [4][4];
  int thr [4];
  int cnt [4];
  bit rv  [4];
  bit st  [4];
  string tag [4];

  initial begin
    wt[0] = '{2, 1, 1, 1}; thr[0] = 3; cnt[0] = 4; rv[0] = 0;
    wt[1] = '{1, 1, 1, 1}; thr[1] = 3; cnt[1] = 3; rv[1] = 0;
    wt[2] = '{1, 1, 1, 1}; thr[2] = 1; cnt[2] = 4; rv[2] = 0;
    wt[3] = '{2, 1, 1, 0}; thr[3] = 2; cnt[3] = 3; rv[3] = 1;
  end

  task automatic model_step(input logic [3:0] v, input logic r);
    for (int i = 0; i < 4; i++) begin
      int s = 0;
      bit anyh = 0;
      for (int k = 0; k < cnt[i]; k++) begin
        if (v[k]) begin
          s += wt[i][k];
          anyh = 1;
        end
      end
      if (r) begin
        st[i] = rv[i]; tag[i] = "R1";
      end else if (!st[i]) begin
        if (s >= thr[i]) begin
          st[i] = 1;
          tag[i] = (i == 0) ? "R6" : (i == 1) ? "R7" : (i == 2) ? "R8" : "R2";
        end else begin
          tag[i] = (i == 0) ? "R6" : "R3";
        end
      end else begin
        if (anyh) tag[i] = (i == 2) ? "R8" : "R4";
        else begin
          st[i] = 0; tag[i] = (i == 1) ? "R7" : "R5";
        end
      end
      if (i == 1 && !r && v[3] && v[2:0] != 3'b111) tag[i] = "R9";
    end
  endtask

  task automatic cycle(input logic [3:0] v, input logic r);
    stim = v;
    rst  = r;
    @(posedge clk);
    model_step(v, r);
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      checks++;
      if (outs[i] !== st[i]) begin
        fails++;
        $display("FAIL %s inst%0d in=%b rst=%b: actual %b expected %b",
                 tag[i], i, v, r, outs[i], st[i]);
      end
    end
  endtask

  initial begin
    // R1: reset with inputs high, both reset values
    cycle(4'b1111, 1'b1);
    cycle(4'b0000, 1'b1);
    // R6: every pattern from the low state, then release
    for (int p = 0; p < 16; p++) begin
      cycle(p[3:0], 1'b0);
      cycle(4'b0000, 1'b0);
      cycle(4'b0000, 1'b0);
    end
    // R4/R5: set, drop to partial set, then idle
    cycle(4'b0011, 1'b0);
    cycle(4'b0001, 1'b0);
    cycle(4'b1000, 1'b0);
    cycle(4'b0000, 1'b0);
    // R3: sub-threshold with inputs high
    cycle(4'b0110, 1'b0);
    cycle(4'b0000, 1'b0);
    // R7/R9: completion gate with high bit above N
    cycle(4'b1000, 1'b0);
    cycle(4'b1011, 1'b0);
    cycle(4'b0111, 1'b0);
    cycle(4'b1100, 1'b0);
    cycle(4'b1000, 1'b0);
    cycle(4'b0000, 1'b0);
    // R1: reset in the middle of a high state has priority
    cycle(4'b1111, 1'b0);
    cycle(4'b1111, 1'b1);
    cycle(4'b1111, 1'b0);
    cycle(4'b0000, 1'b0);
    // Random sequences, mostly release-heavy so both rules get traffic
    for (int n = 0; n < 3000; n++) begin
      logic [3:0] v;
      v = 4'($urandom);
      if (($urandom % 3) == 0) v = 4'b0000;
      cycle(v, (($urandom % 97) == 0));
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule